// File: doc/BRIEF.md
# Latched Fault Status Bank

This block keeps three read-only status bytes for a motor driver's serial register interface. One byte is live: it carries a two-bit temperature range code and a watchdog-event flag. The other two bytes are sticky. Each collects overcurrent, open-coil and supply/thermal fault flags for one coil. A flag stays set until the host reads its byte. Every byte has an even-parity bit in its MSB.

The bank follows its sources only while chip select is deasserted (high). While a transfer is in progress the contents are frozen, so the host reads one consistent snapshot. A read strobe for a sticky byte, seen during the transfer, arms a clear for that byte. The clear is applied on the first clock after chip select returns high. In that same cycle the fault inputs are merged in again, so a fault that is still present stays visible.

The bank also drives an active-low error line and gates the motor-enable request. Both respond to any sticky flag that is set. The serial front end presents a register address and takes the byte back combinationally.

Top module: `fault_status_bank`

## Requirements
- R1: After reset every status byte reads 0x00, err_n is 1, and mot_en follows mot_en_req.
- R2: Address 4 returns bit7 parity, bits 6:5 therm_range, bit4 wd_event and bits 3:0 zero. These are the values the inputs had at the last clock edge where cs_n was high; nothing is held across cycles.
- R3: Address 5 returns bit7 parity, bits 6:3 ovc_x[3:0], bit2 cp_fail, bit1 open_x and bit0 zero.
- R4: Address 6 returns the same layout for the Y coil: ovc_y[3:0], then tsd in bit2, then open_y in bit1.
- R5: Bit7 of every status byte makes the count of ones in the byte even.
- R6: A fault flag seen high at a clock edge with cs_n high stays set after its input returns low.
- R7: At clock edges where cs_n is low, no status byte changes, and fault inputs that are present then are not captured.
- R8: A rd_stb with address 5 or 6 at an edge where cs_n is low clears that byte's sticky bits at the first later edge with cs_n high. Faults still present at that edge are set again in the same cycle.
- R9: A clear affects only the byte that was read.
- R10: A rd_stb while cs_n is high, or a rd_stb for address 4, clears nothing.
- R11: An address other than 4, 5 or 6 returns 0x00.
- R12: err_n is 0 exactly when any sticky bit of byte 5 or byte 6 is set.
- R13: mot_en equals mot_en_req while no sticky bit is set, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select level, already synchronised (low = transfer active) |
| rd_stb | input | 1 | One-cycle pulse marking a completed read of rd_addr |
| rd_addr | input | 5 | Register address being read |
| rd_data | output | 8 | Status byte at rd_addr, or 0x00 |
| ovc_x | input | 4 | X-coil overcurrent flags {P top, P bottom, N top, N bottom} |
| cp_fail | input | 1 | Charge-pump failure flag |
| open_x | input | 1 | X-coil open flag |
| ovc_y | input | 4 | Y-coil overcurrent flags, same order as ovc_x |
| tsd | input | 1 | Thermal shutdown flag |
| open_y | input | 1 | Y-coil open flag |
| therm_range | input | 2 | Live temperature range code |
| wd_event | input | 1 | Live watchdog-event flag |
| mot_en_req | input | 1 | Motor-enable bit from the control register |
| mot_en | output | 1 | Gated motor enable |
| err_n | output | 1 | Active-low error indication |

## Verification
Several properties are checked on every cycle:
- The bank stays frozen across edges where chip select is low.
- Every returned byte has even parity.
- Unmapped addresses read zero.
- A sticky bit falls only when a clear was armed.
- A strobe seen with chip select high arms nothing.
- The enable and error outputs always agree with each other.

Some behaviour only the bench scenarios can show:
- The exact bit placement of each field.
- A fault that persists across a clear and is caught again in the same cycle.
- A pulse that arrives during a transfer and is lost.
- A clear that is confined to the byte that was read.

// File: rtl/fault_status_bank.sv
module fault_status_bank #(
  parameter int AW = 5,
  parameter logic [AW-1:0] A_LIVE = AW'(4),
  parameter logic [AW-1:0] A_XCOIL = AW'(5),
  parameter logic [AW-1:0] A_YCOIL = AW'(6)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          rd_stb,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  input  logic [3:0]    ovc_x,
  input  logic          cp_fail,
  input  logic          open_x,
  input  logic [3:0]    ovc_y,
  input  logic          tsd,
  input  logic          open_y,
  input  logic [1:0]    therm_range,
  input  logic          wd_event,
  input  logic          mot_en_req,
  output logic          mot_en,
  output logic          err_n
);

  logic [2:0] live_q;
  logic [5:0] xs_q, ys_q;
  logic       clr_x, clr_y;
  logic       fault_any;
  logic [6:0] b_live, b_x, b_y;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_q <= '0;
      xs_q   <= '0;
      ys_q   <= '0;
      clr_x  <= 1'b0;
      clr_y  <= 1'b0;
    end else if (cs_n) begin
      live_q <= {therm_range, wd_event};
      xs_q   <= (clr_x ? 6'd0 : xs_q) | {ovc_x, cp_fail, open_x};
      ys_q   <= (clr_y ? 6'd0 : ys_q) | {ovc_y, tsd, open_y};
      clr_x  <= 1'b0;
      clr_y  <= 1'b0;
    end else if (rd_stb) begin
      if (rd_addr == A_XCOIL) clr_x <= 1'b1;
      if (rd_addr == A_YCOIL) clr_y <= 1'b1;
    end
  end

  assign b_live = {live_q, 4'b0000};
  assign b_x    = {xs_q, 1'b0};
  assign b_y    = {ys_q, 1'b0};

  always_comb begin
    if (rd_addr == A_LIVE)       rd_data = {^b_live, b_live};
    else if (rd_addr == A_XCOIL) rd_data = {^b_x, b_x};
    else if (rd_addr == A_YCOIL) rd_data = {^b_y, b_y};
    else                         rd_data = 8'h00;
  end

  assign fault_any = |{xs_q, ys_q};
  assign err_n     = ~fault_any;
  assign mot_en    = mot_en_req & ~fault_any;

endmodule

module fault_status_bank_chk #(
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n,
  input logic          rd_stb,
  input logic [AW-1:0] rd_addr,
  input logic [7:0]    rd_data,
  input logic [5:0]    xs_q,
  input logic [5:0]    ys_q,
  input logic          clr_x,
  input logic          clr_y,
  input logic          mot_en_req,
  input logic          mot_en,
  input logic          err_n
);

  // R7
  frozen_during_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cs_n) |-> ($stable(xs_q) && $stable(ys_q)));

  // R5
  even_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(rd_data) % 2) == 0);

  // R11
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr < AW'(4) || rd_addr > AW'(6)) |-> rd_data == 8'h00);

  // R8
  x_fall_needs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(xs_q) & ~xs_q)) |-> $past(clr_x));

  // R8
  y_fall_needs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(ys_q) & ~ys_q)) |-> $past(clr_y));

  // R10
  idle_strobe_no_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && cs_n) |=> (!clr_x && !clr_y));

  // R13
  enable_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mot_en |-> (mot_en_req && err_n));

  // R13
  enable_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mot_en_req && err_n) |-> mot_en);

endmodule

bind fault_status_bank fault_status_bank_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_stb(rd_stb), .rd_addr(rd_addr),
  .rd_data(rd_data), .xs_q(xs_q), .ys_q(ys_q), .clr_x(clr_x), .clr_y(clr_y),
  .mot_en_req(mot_en_req), .mot_en(mot_en), .err_n(err_n)
);

// File: tb/test_fault_status_bank.sv
module test_fault_status_bank;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, rd_stb = 1'b0;
  logic [4:0] rd_addr = 5'd4;
  logic [7:0] rd_data;
  logic [3:0] ovc_x = '0, ovc_y = '0;
  logic cp_fail = 0, open_x = 0, tsd = 0, open_y = 0, wd_event = 0, mot_en_req = 1;
  logic [1:0] therm_range = '0;
  logic mot_en, err_n;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fault_status_bank i_fault_status_bank (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_stb(rd_stb), .rd_addr(rd_addr),
    .rd_data(rd_data), .ovc_x(ovc_x), .cp_fail(cp_fail), .open_x(open_x),
    .ovc_y(ovc_y), .tsd(tsd), .open_y(open_y), .therm_range(therm_range),
    .wd_event(wd_event), .mot_en_req(mot_en_req), .mot_en(mot_en), .err_n(err_n));

  // behavioural reference
  int m_tr, m_wd, m_x, m_y;
  int armed[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_tr = 0; m_wd = 0; m_x = 0; m_y = 0; armed.delete();
    end else if (!cs_n) begin
      if (rd_stb && (rd_addr == 5 || rd_addr == 6)) armed.push_back(int'(rd_addr));
    end else begin
      foreach (armed[i]) begin
        if (armed[i] == 5) m_x = 0;
        else m_y = 0;
      end
      armed.delete();
      m_tr = therm_range; m_wd = wd_event;
      m_x = m_x | ((ovc_x << 2) + (cp_fail << 1) + open_x);
      m_y = m_y | ((ovc_y << 2) + (tsd << 1) + open_y);
    end
  end

  function automatic int with_par(int low7);
    int n = 0;
    for (int b = 0; b < 7; b++) if ((low7 >> b) & 1) n++;
    return (n % 2) ? (low7 + 128) : low7;
  endfunction

  function automatic int exp_byte(int a);
    case (a)
      4: return with_par(m_tr * 32 + m_wd * 16);
      5: return with_par(m_x * 2);
      6: return with_par(m_y * 2);
      default: return 0;
    endcase
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk((rd_addr == 5) ? "R3" : (rd_addr == 6) ? "R4" : (rd_addr == 4) ? "R2" : "R11",
          int'(rd_data), exp_byte(int'(rd_addr)));
      chk("R12", int'(err_n), (m_x | m_y) == 0);
      chk("R13", int'(mot_en), mot_en_req && ((m_x | m_y) == 0));
    end
  end

  task automatic step(int n = 1);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic rd(int a, string req, int exp);
    rd_addr = 5'(a);
    #1;
    chk(req, int'(rd_data), exp);
  endtask

  initial begin
    #(8 * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step();
    // R1 reset state
    rd(4, "R1", 8'h00); rd(5, "R1", 8'h00); rd(6, "R1", 8'h00);
    chk("R1", int'(err_n), 1); chk("R1", int'(mot_en), 1);
    // R2 / R5 live byte
    therm_range = 2; wd_event = 1; step(); rd(4, "R2", 8'h50);
    therm_range = 1; wd_event = 0; step(); rd(4, "R5", 8'hA0);
    therm_range = 3; step(); rd(4, "R2", 8'h60);
    // R3 / R6 / R12 / R13
    ovc_x = 4'b1000; open_x = 1; step();
    ovc_x = 0; open_x = 0; step();
    rd(5, "R6", 8'h42);
    chk("R12", int'(err_n), 0); chk("R13", int'(mot_en), 0);
    cp_fail = 1; step(); cp_fail = 0; rd(5, "R3", 8'hC6);
    // R4
    tsd = 1; step(); tsd = 0; rd(6, "R4", 8'h84);
    // R7 freeze
    cs_n = 0; open_y = 1; therm_range = 0; step(2);
    open_y = 0; step();
    rd(6, "R7", 8'h84); rd(4, "R7", 8'h60);
    cs_n = 1; step(); rd(6, "R7", 8'h84); rd(4, "R2", 8'h00);
    // R10 strobes while cs_n high, and for address 4
    rd_addr = 5; rd_stb = 1; step(); rd_stb = 0;
    cs_n = 0; rd_addr = 4; rd_stb = 1; step(); rd_stb = 0; cs_n = 1; step();
    rd(5, "R10", 8'hC6);
    // R8 / R9 clear on read, applied after cs_n rises
    cs_n = 0; rd_addr = 5; rd_stb = 1; step(); rd_stb = 0; step();
    rd(5, "R8", 8'hC6);
    cs_n = 1; step();
    rd(5, "R8", 8'h00); rd(6, "R9", 8'h84);
    chk("R12", int'(err_n), 0);
    // R8 re-latch of a persistent fault
    open_y = 1; step();
    cs_n = 0; rd_addr = 6; rd_stb = 1; step(); rd_stb = 0; cs_n = 1; step();
    rd(6, "R8", 8'h82);
    open_y = 0;
    cs_n = 0; rd_stb = 1; step(); rd_stb = 0; cs_n = 1; step();
    rd(6, "R8", 8'h00);
    chk("R12", int'(err_n), 1); chk("R13", int'(mot_en), 1);
    mot_en_req = 0; #1; chk("R13", int'(mot_en), 0);
    // R11 unmapped addresses
    rd(9, "R11", 8'h00); rd(0, "R11", 8'h00); rd(31, "R11", 8'h00);
    step(2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule